// File: doc/BRIEF.md
# Selectable UART Baud Clock Generator

This block produces a sixteen-times-oversampling clock for a UART from a single reference. A 4-bit code, sampled on every clock, picks one of thirteen internally divided bit rates. It can instead pass an external user signal straight to the output. That signal may be a second clock, or a fixed level that stops the UART (zero baud). One code is a spare that forces the output low.

The reference first passes through a divide-by-16 prescaler. The three low prescaler bits and a per-reference-cycle strobe leave the block, so that more channels can be built outside it. A rate stage then divides the prescaled count by an integer. The one exception is 1800 baud, which uses a repeating fractional sequence.

The whole design is synchronous to `clk`. A reference cycle ("source tick") is either every `clk` cycle (internal reference mode) or each rising edge seen on `step_in` (external step mode). An edge-detecting initialization clears all counters when `step_in` first goes high after external step mode is entered. While internal reference mode is selected, `step_in` must stay low: holding it high keeps the counters cleared.

Top module: `baud_clock_gen`

## Requirements
- R1: The prescaler is a 4-bit count of source ticks that wraps from 15 to 0. `pre_tap` shows its three low bits.
- R2: With `int_ref_sel`=1 every `clk` cycle is a source tick. With `int_ref_sel`=0 a source tick is a cycle where `step_in` is high and was low in the previous cycle. `ref_strobe` is high exactly in source-tick cycles.
- R3: While `int_ref_sel`=1 and `step_in`=1, all counters are cleared on every clock. After `int_ref_sel` goes low, the first cycle with `step_in` high clears the counters once, and that tick does not advance them. Later `step_in` highs do not clear them until `int_ref_sel` has been high again.
- R4: For an integer code with divisor N, `baud_x16` has a period of 16·N source ticks. It is high while (rate count·16 + prescaler count) < 8·N. The divisors are: code 3→1 (9600), 4→2 (4800), 6→16 (600), 8→48 (200), 9→71 (134.5), A→128 (75), C→192 (50).
- R5: Five rates are reached with at most one select bit low: F→4 (2400), E→8 (1200), D→32 (300), B→64 (150), 7→87 (110).
- R6: Code 5 (1800 baud) repeats periods of 85, 85 and 86 source ticks. Each period is high for its first 43 ticks.
- R7: Codes 1 and 2 drive `baud_x16` from `user_clk` with no register in the path.
- R8: Code 0 holds `baud_x16` low.
- R9: `rate_sel` is registered on every clock. When it differs from the held code, the rate counters clear and the new code takes effect in the next cycle. The prescaler keeps counting through the change.
- R10: A synchronous `rst` clears all counters and sets the held code to 0, so `baud_x16` is low during reset.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| int_ref_sel | input | 1 | 1: every clk is a source tick; 0: rising edges of step_in are ticks |
| step_in | input | 1 | External step / initialization input |
| rate_sel | input | 4 | Rate select code |
| user_clk | input | 1 | User signal passed through on codes 1 and 2 |
| baud_x16 | output | 1 | 16x oversampling clock |
| ref_strobe | output | 1 | High in each source-tick cycle |
| pre_tap | output | 3 | Low three bits of the prescaler count |

## Verification
The bench builds the block with its default parameters: a 4-bit prescaler and an 8-bit rate counter. These allow the longest period, 3072 source ticks for the 50 baud code, to be observed twice within the run. Because internal reference mode gives one source tick per clock, every code is swept at full speed. The bench also covers the external step mode with one- and two-cycle high pulses, the hold-clear and one-shot initialization sequences, and a rate change part-way through a period.

// File: rtl/bcg_pkg.sv
package bcg_pkg;

    localparam int SEL_W      = 4;
    localparam int DIV_W      = 8;
    localparam int FRAC_W     = 7;
    localparam int FRAC_SHORT = 85;
    localparam int FRAC_LONG  = 86;
    localparam int FRAC_HIGH  = 43;
    localparam int FRAC_STEPS = 3;
    localparam int STEP_W     = $clog2(FRAC_STEPS);

    typedef enum logic [1:0] {
        K_SPARE,
        K_USER,
        K_FRAC,
        K_INT
    } rate_kind_e;

    typedef struct packed {
        rate_kind_e       kind;
        logic [DIV_W-1:0] div;
    } rate_cfg_t;

    // Code to rate mapping; low-activity codes place common rates on one-low patterns.
    function automatic rate_cfg_t decode_rate(input logic [SEL_W-1:0] code);
        rate_cfg_t c;
        c.kind = K_INT;
        c.div  = DIV_W'(1);
        case (code)
            4'h0:       c.kind = K_SPARE;
            4'h1, 4'h2: c.kind = K_USER;
            4'h5:       c.kind = K_FRAC;
            4'h3:       c.div  = DIV_W'(1);
            4'h4:       c.div  = DIV_W'(2);
            4'hF:       c.div  = DIV_W'(4);
            4'hE:       c.div  = DIV_W'(8);
            4'h6:       c.div  = DIV_W'(16);
            4'hD:       c.div  = DIV_W'(32);
            4'h8:       c.div  = DIV_W'(48);
            4'hB:       c.div  = DIV_W'(64);
            4'h9:       c.div  = DIV_W'(71);
            4'h7:       c.div  = DIV_W'(87);
            4'hA:       c.div  = DIV_W'(128);
            4'hC:       c.div  = DIV_W'(192);
            default:    c.div  = DIV_W'(1);
        endcase
        return c;
    endfunction

endpackage

// File: rtl/bcg_clk_front.sv
module bcg_clk_front (
    input  logic clk,
    input  logic rst,
    input  logic int_ref_sel,
    input  logic step_in,
    output logic tick,
    output logic init
);

    logic step_d;
    logic armed;

    always_ff @(posedge clk) begin
        if (rst) begin
            step_d <= 1'b0;
            armed  <= 1'b1;
        end else begin
            step_d <= step_in;
            if (int_ref_sel)
                armed <= 1'b1;
            else if (step_in)
                armed <= 1'b0;
        end
    end

    assign tick = int_ref_sel | (step_in & ~step_d);
    assign init = step_in & (int_ref_sel | armed);

endmodule

// File: rtl/bcg_prescaler.sv
module bcg_prescaler #(
    parameter int PRE_W = 4
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             tick,
    output logic [PRE_W-1:0] cnt,
    output logic             wrap
);

    always_ff @(posedge clk) begin
        if (rst || clr)
            cnt <= '0;
        else if (tick)
            cnt <= cnt + 1'b1;
    end

    assign wrap = tick & (cnt == '1);

    // R1: each accepted tick advances the count by one
    a_r1_pre_step: assert property (@(posedge clk) disable iff (rst)
        (tick && !clr) |=> (cnt == PRE_W'($past(cnt) + 1'b1)));

endmodule

// File: rtl/bcg_int_div.sv
module bcg_int_div #(
    parameter int PRE_W = 4,
    parameter int DIV_W = 8
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             clr,
    input  logic             wrap,
    input  logic [DIV_W-1:0] div,
    input  logic [PRE_W-1:0] pre_cnt,
    output logic [DIV_W-1:0] rc,
    output logic             hi
);

    localparam int PH_W = DIV_W + PRE_W;

    logic [PH_W-1:0] phase;
    logic [PH_W-1:0] half;

    always_ff @(posedge clk) begin
        if (rst || clr)
            rc <= '0;
        else if (wrap)
            rc <= (rc == div - 1'b1) ? '0 : rc + 1'b1;
    end

    assign phase = {rc, pre_cnt};
    assign half  = {1'b0, div, {(PRE_W-1){1'b0}}};
    assign hi    = phase < half;

    // R4: the rate count never reaches the divisor
    a_r4_rc_bound: assert property (@(posedge clk) disable iff (rst)
        rc < div);

endmodule

// File: rtl/bcg_frac_div.sv
module bcg_frac_div #(
    parameter int FRAC_W = bcg_pkg::FRAC_W,
    parameter int STEP_W = bcg_pkg::STEP_W
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              clr,
    input  logic              tick,
    output logic [FRAC_W-1:0] fc,
    output logic              hi
);

    localparam logic [FRAC_W-1:0] LAST_S = FRAC_W'(bcg_pkg::FRAC_SHORT - 1);
    localparam logic [FRAC_W-1:0] LAST_L = FRAC_W'(bcg_pkg::FRAC_LONG - 1);
    localparam logic [STEP_W-1:0] STEP_E = STEP_W'(bcg_pkg::FRAC_STEPS - 1);

    logic [STEP_W-1:0] step;
    logic [FRAC_W-1:0] last;

    assign last = (step == STEP_E) ? LAST_L : LAST_S;

    always_ff @(posedge clk) begin
        if (rst || clr) begin
            fc   <= '0;
            step <= '0;
        end else if (tick) begin
            if (fc == last) begin
                fc   <= '0;
                step <= (step == STEP_E) ? '0 : step + 1'b1;
            end else begin
                fc <= fc + 1'b1;
            end
        end
    end

    assign hi = fc < FRAC_W'(bcg_pkg::FRAC_HIGH);

    // R6: counter and sequence index stay inside the 85/85/86 pattern
    a_r6_frac_bound: assert property (@(posedge clk) disable iff (rst)
        (fc < FRAC_W'(bcg_pkg::FRAC_LONG)) && (step <= STEP_E));

endmodule

// File: rtl/baud_clock_gen.sv
module baud_clock_gen #(
    parameter int PRE_W = 4,
    parameter int TAP_W = 3
) (
    input  logic                      clk,
    input  logic                      rst,
    input  logic                      int_ref_sel,
    input  logic                      step_in,
    input  logic [bcg_pkg::SEL_W-1:0] rate_sel,
    input  logic                      user_clk,
    output logic                      baud_x16,
    output logic                      ref_strobe,
    output logic [TAP_W-1:0]          pre_tap
);

    localparam int SEL_W  = bcg_pkg::SEL_W;
    localparam int DIV_W  = bcg_pkg::DIV_W;
    localparam int FRAC_W = bcg_pkg::FRAC_W;

    logic              tick;
    logic              init;
    logic              restart;
    logic              clr;
    logic [SEL_W-1:0]  cur;
    bcg_pkg::rate_cfg_t cfg;
    logic [PRE_W-1:0]  pre_cnt;
    logic              wrap;
    logic [DIV_W-1:0]  rc_cnt;
    logic              int_hi;
    logic [FRAC_W-1:0] fc_cnt;
    logic              frac_hi;

    bcg_clk_front u_front (
        .clk         (clk),
        .rst         (rst),
        .int_ref_sel (int_ref_sel),
        .step_in     (step_in),
        .tick        (tick),
        .init        (init)
    );

    always_ff @(posedge clk) begin
        if (rst)
            cur <= '0;
        else
            cur <= rate_sel;
    end

    assign restart = (rate_sel != cur);
    assign clr     = init | restart;
    assign cfg     = bcg_pkg::decode_rate(cur);

    bcg_prescaler #(.PRE_W(PRE_W)) u_pre (
        .clk  (clk),
        .rst  (rst),
        .clr  (init),
        .tick (tick),
        .cnt  (pre_cnt),
        .wrap (wrap)
    );

    bcg_int_div #(.PRE_W(PRE_W), .DIV_W(DIV_W)) u_int (
        .clk     (clk),
        .rst     (rst),
        .clr     (clr),
        .wrap    (wrap),
        .div     (cfg.div),
        .pre_cnt (pre_cnt),
        .rc      (rc_cnt),
        .hi      (int_hi)
    );

    bcg_frac_div u_frac (
        .clk  (clk),
        .rst  (rst),
        .clr  (clr),
        .tick (tick),
        .fc   (fc_cnt),
        .hi   (frac_hi)
    );

    always_comb begin
        case (cfg.kind)
            bcg_pkg::K_SPARE: baud_x16 = 1'b0;
            bcg_pkg::K_USER:  baud_x16 = user_clk;
            bcg_pkg::K_FRAC:  baud_x16 = frac_hi;
            default:          baud_x16 = int_hi;
        endcase
    end

    assign ref_strobe = tick;
    assign pre_tap    = pre_cnt[TAP_W-1:0];

    // R3: internal reference mode with step_in high leaves the prescaler cleared
    a_r3_hold_clear: assert property (@(posedge clk) disable iff (rst)
        (int_ref_sel && step_in) |=> (pre_cnt == '0));

    // R7: pass-through codes follow the user input
    a_r7_user_pass: assert property (@(posedge clk) disable iff (rst)
        (cur == SEL_W'(1) || cur == SEL_W'(2)) |-> (baud_x16 == user_clk));

    // R8: spare code keeps the output low
    a_r8_spare_low: assert property (@(posedge clk) disable iff (rst)
        (cur == '0) |-> !baud_x16);

    // R9: a new select code restarts both rate counters
    a_r9_restart_clear: assert property (@(posedge clk) disable iff (rst)
        (rate_sel != cur) |=> (rc_cnt == '0 && fc_cnt == '0));

endmodule

// File: tb/test_baud_clock_gen.sv
module test_baud_clock_gen;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       int_ref_sel = 1'b1;
    logic       step_in = 1'b0;
    logic       user_clk = 1'b0;
    logic [3:0] rate_sel = 4'h0;
    logic       baud_x16;
    logic       ref_strobe;
    logic [2:0] pre_tap;

    always #10 clk = ~clk;

    baud_clock_gen i_baud_clock_gen (
        .clk         (clk),
        .rst         (rst),
        .int_ref_sel (int_ref_sel),
        .step_in     (step_in),
        .rate_sel    (rate_sel),
        .user_clk    (user_clk),
        .baud_x16    (baud_x16),
        .ref_strobe  (ref_strobe),
        .pre_tap     (pre_tap)
    );

    // Behavioural reference state
    int    m_pre = 0, m_rc = 0, m_fc = 0, m_sq = 0, m_cur = 0, m_cpd = 0, m_arm = 1;
    bit    chk_on = 0;
    bit    done = 0;
    bit    tog_user = 0;
    string req = "R10";
    int    vectors = 0;
    int    miscompares = 0;

    function automatic int ref_div(int code);
        case (code)
            3: return 1;    4: return 2;    15: return 4;   14: return 8;
            6: return 16;   13: return 32;  8: return 48;   11: return 64;
            9: return 71;   7: return 87;   10: return 128; 12: return 192;
            default: return 1;
        endcase
    endfunction

    function automatic string tag_of(int code);
        if (code == 0) return "R8";
        if (code == 1 || code == 2) return "R7";
        if (code == 5) return "R6";
        if (code == 15 || code == 14 || code == 13 || code == 11 || code == 7) return "R5";
        return "R4";
    endfunction

    function automatic bit exp_baud();
        if (m_cur == 0) return 1'b0;
        if (m_cur == 1 || m_cur == 2) return user_clk;
        if (m_cur == 5) return (m_fc < 43);
        return ((m_rc * 16 + m_pre) < 8 * ref_div(m_cur));
    endfunction

    function automatic bit exp_strobe();
        return int_ref_sel || (step_in && (m_cpd == 0));
    endfunction

    always @(posedge clk) begin
        int  tk;
        int  ini;
        int  rs;
        int  wr;
        int  len;
        if (rst) begin
            m_pre = 0; m_rc = 0; m_fc = 0; m_sq = 0; m_cur = 0; m_cpd = 0; m_arm = 1;
        end else begin
            tk  = (int_ref_sel || (step_in && m_cpd == 0)) ? 1 : 0;
            ini = (step_in && (int_ref_sel || m_arm == 1)) ? 1 : 0;
            rs  = (int'(rate_sel) != m_cur) ? 1 : 0;
            wr  = (tk == 1 && m_pre == 15) ? 1 : 0;
            if (ini == 1 || rs == 1) begin
                m_rc = 0; m_fc = 0; m_sq = 0;
            end else begin
                if (wr == 1) m_rc = (m_rc + 1) % ref_div(m_cur);
                if (tk == 1) begin
                    len = (m_sq == 2) ? 86 : 85;
                    if (m_fc == len - 1) begin
                        m_fc = 0; m_sq = (m_sq + 1) % 3;
                    end else m_fc = m_fc + 1;
                end
            end
            if (ini == 1) m_pre = 0;
            else if (tk == 1) m_pre = (m_pre + 1) % 16;
            if (int_ref_sel) m_arm = 1;
            else if (step_in) m_arm = 0;
            m_cpd = step_in ? 1 : 0;
            m_cur = int'(rate_sel);
        end
    end

    always @(negedge clk) begin
        if (chk_on && !done) begin
            vectors++;
            if (baud_x16 !== exp_baud()) begin
                miscompares++;
                $display("FAIL %s baud_x16 act=%b exp=%b code=%0d t=%0t", req, baud_x16, exp_baud(), m_cur, $time);
            end
            vectors++;
            if (pre_tap !== 3'(m_pre % 8)) begin
                miscompares++;
                $display("FAIL R1 pre_tap act=%0d exp=%0d t=%0t", pre_tap, m_pre % 8, $time);
            end
            vectors++;
            if (ref_strobe !== exp_strobe()) begin
                miscompares++;
                $display("FAIL R2 ref_strobe act=%b exp=%b t=%0t", ref_strobe, exp_strobe(), $time);
            end
        end
    end

    task automatic drive_wait(input int n);
        for (int i = 0; i < n; i++) begin
            @(posedge clk);
            #2;
            if (tog_user && (i % 7 == 3)) user_clk = ~user_clk;
        end
    endtask

    task automatic step_pulses(input int count, input int hi, input int lo);
        for (int k = 0; k < count; k++) begin
            step_in = 1'b1;
            drive_wait(hi);
            step_in = 1'b0;
            drive_wait(lo);
        end
    endtask

    task automatic finish_run();
        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            miscompares++;
            $display("FAIL R10 watchdog act=running exp=finished");
            finish_run();
        end
    end

    initial begin
        // R10: reset state
        req = "R10";
        @(posedge clk);
        #2;
        chk_on = 1;
        rate_sel = 4'h7;
        drive_wait(4);
        rst = 1'b0;

        // R4 R5 R6 R7 R8: sweep every code on the internal reference
        for (int code = 0; code < 16; code++) begin
            int len;
            req = tag_of(code);
            rate_sel = 4'(code);
            tog_user = (code == 1 || code == 2);
            if (code == 0) len = 50;
            else if (code == 1 || code == 2) len = 100;
            else if (code == 5) len = 600;
            else len = 2 * 16 * ref_div(code) + 40;
            drive_wait(len);
        end
        tog_user = 0;

        // R9: rate changes part-way through a period
        req = "R9";
        rate_sel = 4'h7;
        drive_wait(500);
        rate_sel = 4'hE;
        drive_wait(300);
        rate_sel = 4'h5;
        drive_wait(100);
        rate_sel = 4'h3;
        drive_wait(40);

        // R3: step_in high in internal mode holds the clear
        req = "R3";
        step_in = 1'b1;
        drive_wait(20);
        step_in = 1'b0;
        drive_wait(3);
        int_ref_sel = 1'b0;
        drive_wait(3);

        // R2: external step mode, first edge also initializes (R3)
        req = "R2";
        step_pulses(150, 2, 3);

        // R3: re-arm through internal mode, then one-cycle pulses on 1800 baud
        req = "R3";
        int_ref_sel = 1'b1;
        drive_wait(10);
        int_ref_sel = 1'b0;
        rate_sel = 4'h5;
        drive_wait(2);
        step_pulses(200, 1, 1);

        // R10: reset in mid-run
        req = "R10";
        int_ref_sel = 1'b1;
        rst = 1'b1;
        drive_wait(3);
        rst = 1'b0;
        drive_wait(20);

        finish_run();
    end

endmodule